// File: doc/BRIEF.md
# Polynomial Sensor Compensation Datapath

This block turns one raw sensor reading and one raw temperature reading into a corrected output word. It applies a second-order temperature correction to both the sensitivity and the offset of the sensor, multiplies the two corrected terms, and then adds an output pedestal:

`result = Gain * (1 + G1*T + G2*T^2) * (Signal + Of0 + Of1*T + Of2*T^2) + Doff`

The engine is sequential and uses a single signed multiplier. A one-cycle `start` strobe captures the two readings and the seven coefficients. Seven multiply-accumulate steps follow. A one-cycle `done` pulse then marks a new 16-bit result and its 12-bit unsigned form. Coefficient storage, analog conversion and any host access sit outside this block.

Top module: `sens_comp`

## Requirements
- R1: Reset state. While reset is applied and after it is released, `busy` and `done` are 0, `result` is 0 and `result12` is 0x800.
- R2: Latency. A `start` that is high while `busy` is 0 is accepted at that rising edge, and all inputs are captured there. `done` is high during the cycle that follows the seventh rising edge after the accepting edge.
- R3: Q15 rounding. Each product of two 16-bit signed operands is computed as `(a*b + 2^14) >>> 15`. This rounds half toward plus infinity, so 1 x 0x4000 gives 1.
- R4: Saturation. Every rounded product and every sum clamps to the range -32768..+32767 and never wraps. For example, 0x8000 x 0x8000 gives +32767.
- R5: Step order. Each step is `sat(c + round(a*b))`, and the steps run in this order:
  - T2 = T*T
  - g = G1*T
  - g = g + G2*T2
  - ge = Gain + Gain*g
  - o = sat(Signal+Of0) + Of1*T
  - o = o + Of2*T2
  - result = Doff + ge*o
  
  Gain and Doff are integers. G1, G2, Of0, Of1, Of2, Signal and T are Q15 fractions.
- R6: `result12` equals bits 15..4 of `result` with bit 11 inverted, so 0x8000 maps to 0x000 and 0x7FFF maps to 0xFFF.
- R7: `done` is high for exactly one cycle per accepted `start`.
- R8: A `start` that arrives while `busy` is 1 is ignored. It produces no extra `done`, and it does not change the result of the run in progress.
- R9: `result` and `result12` change only in a cycle in which `done` is high. They hold their value until the next computation completes.
- R10: `busy` is 1 from the cycle after the accepting edge up to the cycle before `done`. It is 0 while `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized internally |
| start | input | 1 | Start strobe; sampled when idle |
| sig_in | input | 16 | Digitized sensor sample, Q15 |
| temp_in | input | 16 | Digitized temperature sample, Q15 |
| k_gain | input | 16 | Sensitivity coefficient, integer |
| k_g1 | input | 16 | Linear temperature gain term, Q15 |
| k_g2 | input | 16 | Quadratic temperature gain term, Q15 |
| k_of0 | input | 16 | Offset term, Q15 |
| k_of1 | input | 16 | Linear temperature offset term, Q15 |
| k_of2 | input | 16 | Quadratic temperature offset term, Q15 |
| k_doff | input | 16 | Output pedestal, integer |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Signed corrected result |
| result12 | output | 12 | Offset-binary 12-bit output word |

## Verification
The assertions watch the control behaviour on every cycle:
- `done` lasts a single cycle and never overlaps `busy`.
- `busy` holds through every step and ignores a new strobe.
- `result` moves only with `done`.
- The multiplier's extreme-product clamp and half-up rounding hold on each combination of operands they guard.

Only the bench's scenarios can show the rest:
- the numeric correctness of the full seven-step polynomial against an independent model;
- the exact latency;
- saturation of intermediate sums deep inside a run;
- the fact that a strobe during a run leaves that run's result untouched.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [2:0] {
    ST_T2   = 3'd0,
    ST_G1T  = 3'd1,
    ST_GT   = 3'd2,
    ST_GEFF = 3'd3,
    ST_OT1  = 3'd4,
    ST_OT   = 3'd5,
    ST_RES  = 3'd6
  } step_e;

  localparam int unsigned N_STEPS = 7;
endpackage

// File: rtl/sc_seq.sv
module sc_seq
  import sc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  output logic  load,
  output logic  busy,
  output step_e step,
  output logic  last,
  output logic  done
);
  logic  busy_q, busy_d;
  step_e step_q, step_d;
  logic  done_q, done_d;

  always_comb begin
    load   = start && !busy_q;
    last   = busy_q && (step_q == ST_RES);
    busy_d = busy_q;
    step_d = step_q;
    done_d = 1'b0;
    if (load) begin
      busy_d = 1'b1;
      step_d = ST_T2;
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        step_d = step_e'(3'(step_q) + 3'd1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= ST_T2;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign step = step_q;
  assign done = done_q;

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: an active run cannot be cut short or restarted before its last step
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && step_q != ST_RES) |=> busy_q);

  // R10: done and busy never overlap
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  // R2: step index stays within the seven-step schedule
  assert_step_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (3'(step_q) < 3'(N_STEPS)));
endmodule

// File: rtl/sc_opsel.sv
module sc_opsel
  import sc_pkg::*;
#(
  parameter int DW = 16
) (
  input  step_e                step,
  input  logic signed [DW-1:0] sig,
  input  logic signed [DW-1:0] temp,
  input  logic signed [DW-1:0] gain,
  input  logic signed [DW-1:0] g1,
  input  logic signed [DW-1:0] g2,
  input  logic signed [DW-1:0] of0,
  input  logic signed [DW-1:0] of1,
  input  logic signed [DW-1:0] of2,
  input  logic signed [DW-1:0] doff,
  input  logic signed [DW-1:0] t2,
  input  logic signed [DW-1:0] acc,
  input  logic signed [DW-1:0] geff,
  output logic signed [DW-1:0] op_a,
  output logic signed [DW-1:0] op_b,
  output logic signed [DW-1:0] op_c
);
  logic signed [DW:0]   pre_sum;
  logic signed [DW-1:0] pre_sat;

  // saturating pre-add of sample and base offset
  always_comb begin
    pre_sum = {sig[DW-1], sig} + {of0[DW-1], of0};
    if (pre_sum[DW] != pre_sum[DW-1])
      pre_sat = pre_sum[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    else
      pre_sat = pre_sum[DW-1:0];
  end

  always_comb begin
    op_a = '0;
    op_b = '0;
    op_c = '0;
    unique case (step)
      ST_T2:   begin op_a = temp; op_b = temp; op_c = '0;      end
      ST_G1T:  begin op_a = g1;   op_b = temp; op_c = '0;      end
      ST_GT:   begin op_a = g2;   op_b = t2;   op_c = acc;     end
      ST_GEFF: begin op_a = gain; op_b = acc;  op_c = gain;    end
      ST_OT1:  begin op_a = of1;  op_b = temp; op_c = pre_sat; end
      ST_OT:   begin op_a = of2;  op_b = t2;   op_c = acc;     end
      ST_RES:  begin op_a = geff; op_b = acc;  op_c = doff;    end
      default: begin op_a = '0;   op_b = '0;   op_c = '0;      end
    endcase
  end
endmodule

// File: rtl/sc_qmac.sv
module sc_qmac #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  input  logic signed [DW-1:0] c,
  output logic signed [DW-1:0] r
);
  localparam int FRAC = DW - 1;
  localparam int PW   = 2 * DW;
  localparam logic signed [PW:0] HI = {{(PW-DW+2){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW:0] LO = {{(PW-DW+2){1'b1}}, {(DW-1){1'b0}}};
  localparam logic signed [PW:0] HALF = (PW+1)'(1) <<< (FRAC-1);
  localparam logic signed [DW-1:0] MAXW = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINW = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] ONEW = {{(DW-1){1'b0}}, 1'b1};
  localparam logic signed [DW-1:0] HALFW = {2'b01, {(DW-2){1'b0}}};

  logic signed [PW-1:0] prod;
  logic signed [PW:0]   rnd;
  logic signed [PW:0]   shf;
  logic signed [DW-1:0] q;
  logic signed [DW:0]   sum;

  always_comb begin
    prod = a * b;
    rnd  = {prod[PW-1], prod} + HALF;
    shf  = rnd >>> FRAC;
    if (shf > HI)      q = MAXW;
    else if (shf < LO) q = MINW;
    else               q = shf[DW-1:0];
    sum = {q[DW-1], q} + {c[DW-1], c};
    if (sum[DW] != sum[DW-1]) r = sum[DW] ? MINW : MAXW;
    else                      r = sum[DW-1:0];
  end

  always_comb begin
    // R4: the one product that exceeds the range clamps instead of wrapping
    if (a == MINW && b == MINW && c == '0)
      assert_qmac_sat_R4: assert (r == MAXW);
    // R3: an exact half rounds upward
    if (a == ONEW && b == HALFW && c == '0)
      assert_qmac_round_R3: assert (r == ONEW);
  end
endmodule

// File: rtl/sens_comp.sv
module sens_comp
  import sc_pkg::*;
#(
  parameter int DW = 16,
  parameter int OW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [DW-1:0] sig_in,
  input  logic signed [DW-1:0] temp_in,
  input  logic signed [DW-1:0] k_gain,
  input  logic signed [DW-1:0] k_g1,
  input  logic signed [DW-1:0] k_g2,
  input  logic signed [DW-1:0] k_of0,
  input  logic signed [DW-1:0] k_of1,
  input  logic signed [DW-1:0] k_of2,
  input  logic signed [DW-1:0] k_doff,
  output logic                 busy,
  output logic                 done,
  output logic signed [DW-1:0] result,
  output logic [OW-1:0]        result12
);
  localparam int NCAP = 9;
  localparam int CSIG = 0, CTMP = 1, CGN = 2, CG1 = 3, CG2 = 4;
  localparam int COF0 = 5, COF1 = 6, COF2 = 7, CDOF = 8;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_i = rs_q[1];

  logic  load, last;
  step_e step;

  sc_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n_i),
    .start (start),
    .load  (load),
    .busy  (busy),
    .step  (step),
    .last  (last),
    .done  (done)
  );

  // operand capture bank
  logic signed [DW-1:0] cap_in [NCAP];
  logic signed [DW-1:0] cap_q  [NCAP];
  logic signed [DW-1:0] cap_d  [NCAP];

  always_comb begin
    cap_in[CSIG] = sig_in;
    cap_in[CTMP] = temp_in;
    cap_in[CGN]  = k_gain;
    cap_in[CG1]  = k_g1;
    cap_in[CG2]  = k_g2;
    cap_in[COF0] = k_of0;
    cap_in[COF1] = k_of1;
    cap_in[COF2] = k_of2;
    cap_in[CDOF] = k_doff;
  end

  for (genvar gi = 0; gi < NCAP; gi++) begin : g_cap
    always_comb cap_d[gi] = load ? cap_in[gi] : cap_q[gi];
    always_ff @(posedge clk or negedge rst_n_i) begin
      if (!rst_n_i) cap_q[gi] <= '0;
      else          cap_q[gi] <= cap_d[gi];
    end
  end

  // working registers
  logic signed [DW-1:0] t2_q, acc_q, geff_q, res_q;
  logic signed [DW-1:0] t2_d, acc_d, geff_d, res_d;
  logic signed [DW-1:0] op_a, op_b, op_c, mac_r;
  logic                 en_t2, en_acc, en_geff, en_res;

  sc_opsel #(.DW(DW)) u_opsel (
    .step (step),
    .sig  (cap_q[CSIG]),
    .temp (cap_q[CTMP]),
    .gain (cap_q[CGN]),
    .g1   (cap_q[CG1]),
    .g2   (cap_q[CG2]),
    .of0  (cap_q[COF0]),
    .of1  (cap_q[COF1]),
    .of2  (cap_q[COF2]),
    .doff (cap_q[CDOF]),
    .t2   (t2_q),
    .acc  (acc_q),
    .geff (geff_q),
    .op_a (op_a),
    .op_b (op_b),
    .op_c (op_c)
  );

  sc_qmac #(.DW(DW)) u_qmac (
    .a (op_a),
    .b (op_b),
    .c (op_c),
    .r (mac_r)
  );

  always_comb begin
    en_t2   = busy && (step == ST_T2);
    en_acc  = busy && (step == ST_G1T || step == ST_GT ||
                       step == ST_OT1 || step == ST_OT);
    en_geff = busy && (step == ST_GEFF);
    en_res  = last;
    t2_d    = en_t2   ? mac_r : t2_q;
    acc_d   = en_acc  ? mac_r : acc_q;
    geff_d  = en_geff ? mac_r : geff_q;
    res_d   = en_res  ? mac_r : res_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      t2_q   <= '0;
      acc_q  <= '0;
      geff_q <= '0;
      res_q  <= '0;
    end else begin
      t2_q   <= t2_d;
      acc_q  <= acc_d;
      geff_q <= geff_d;
      res_q  <= res_d;
    end
  end

  assign result   = res_q;
  assign result12 = {~res_q[DW-1], res_q[DW-2:DW-OW]};

  // R9: the result register moves only together with the done pulse
  assert_result_stable_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    !done |-> $stable(result));

  // R10: the final write happens in a busy cycle
  assert_res_write_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    en_res |-> busy);
endmodule

// File: tb/sens_comp_tb.sv
module sens_comp_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [15:0] sig_in = '0, temp_in = '0, k_gain = '0, k_g1 = '0, k_g2 = '0;
  logic signed [15:0] k_of0 = '0, k_of1 = '0, k_of2 = '0, k_doff = '0;
  logic busy, done;
  logic signed [15:0] result;
  logic [11:0] result12;

  always #2 clk = ~clk;

  sens_comp u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .sig_in(sig_in), .temp_in(temp_in),
    .k_gain(k_gain), .k_g1(k_g1), .k_g2(k_g2),
    .k_of0(k_of0), .k_of1(k_of1), .k_of2(k_of2), .k_doff(k_doff),
    .busy(busy), .done(done), .result(result), .result12(result12)
  );

  typedef struct {
    int res;
    int r12;
    int cyc;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0;
  int   cyc = 0;
  bit   mon_on = 1'b0;
  bit   ended = 1'b0;
  logic signed [15:0] last_res = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- reference model (from requirements) ----------------
  function automatic int bsat(longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int bmac(int a, int b, int c);
    longint p;
    p = longint'(a) * longint'(b) + 64'sd16384;
    p = p >>> 15;
    return bsat(longint'(c) + longint'(bsat(p)));
  endfunction

  function automatic int model(int s, int t, int gn, int g1, int g2,
                               int o0, int o1, int o2, int df);
    int t2, g, ge, o;
    t2 = bmac(t, t, 0);
    g  = bmac(g1, t, 0);
    g  = bmac(g2, t2, g);
    ge = bmac(gn, g, gn);
    o  = bmac(o1, t, bsat(longint'(s) + longint'(o0)));
    o  = bmac(o2, t2, o);
    return bmac(ge, o, df);
  endfunction

  function automatic int to12(int r);
    return ((r + 32768) >> 4) & 12'hFFF;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- driver ----------------
  task automatic apply(int s, int t, int gn, int g1, int g2,
                       int o0, int o1, int o2, int df);
    sig_in = 16'(s); temp_in = 16'(t); k_gain = 16'(gn);
    k_g1 = 16'(g1); k_g2 = 16'(g2); k_of0 = 16'(o0);
    k_of1 = 16'(o1); k_of2 = 16'(o2); k_doff = 16'(df);
    start = 1'b1;
  endtask

  task automatic run_vec(int s, int t, int gn, int g1, int g2,
                         int o0, int o1, int o2, int df, string tag, int fixed_exp, bit use_fixed);
    exp_t e;
    int   r;
    @(negedge clk);
    apply(s, t, gn, g1, g2, o0, o1, o2, df);
    r = use_fixed ? fixed_exp : model(s, t, gn, g1, g2, o0, o1, o2, df);
    e.res = r; e.r12 = to12(r); e.cyc = cyc + 8; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
    repeat (9) @(negedge clk);
    chk(busy == 1'b0, "R10 busy after done", int'(busy), 0);
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (mon_on) begin
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(int'(result) == e.res, {"R5 result ", e.tag}, int'(result), e.res);
          chk(int'(result12) == e.r12, {"R6 result12 ", e.tag}, int'(result12), e.r12);
          chk(cyc == e.cyc, {"R2 latency ", e.tag}, cyc, e.cyc);
          chk(!busy, "R10 busy with done", int'(busy), 0);
        end
        last_res = result;
      end else begin
        chk(result == last_res, "R9 result held", int'(result), int'(last_res));
      end
    end
  end

  // R7: a done pulse never lasts two sampled cycles
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (mon_on && prev_done && done)
      chk(1'b0, "R7 done width", 2, 1);
    prev_done = done;
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, during reset and after release
    chk(busy == 1'b0 && done == 1'b0, "R1 flags in reset", int'({busy, done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 flags after reset", int'({busy, done}), 0);
    chk(result == 16'sd0, "R1 result", int'(result), 0);
    chk(result12 == 12'h800, "R1 result12", int'(result12), 'h800);
    mon_on = 1'b1;

    // R5/R6 directed: gain near 1, sample 0.5 -> 0x4000, word 0xC00
    run_vec(16384, 0, 32767, 0, 0, 0, 0, 0, 0, "R5 directed half", 16384, 1'b1);
    // R3: 1 x 0.5 on the final product rounds up to 1 (gain 1, o=0.5)
    run_vec(16384, 0, 1, 0, 0, 0, 0, 0, 0, "R3 round half", 1, 1'b1);
    // R4: positive saturation of sample + offset and of the result
    run_vec(32767, 0, 32767, 0, 0, 32767, 0, 0, 32767, "R4 pos sat", 32767, 1'b1);
    // R4: negative extreme temperature squared and product clamp
    run_vec(-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768, "R4 neg corners", 0, 1'b0);
    // R6: most negative result -> word 0x000
    run_vec(-32768, 0, 32767, 0, 0, 0, 0, 0, -32768, "R6 min word", -32768, 1'b1);
    // R5: temperature-dependent gain and offset
    run_vec(1000, 12000, 20000, 3000, -2000, 500, 700, -900, 100, "R5 temp terms", 0, 1'b0);
    run_vec(-5000, -20000, -15000, -8000, 9000, -1200, 4000, 2500, -300, "R5 negative mix", 0, 1'b0);

    // R8: second strobe while busy is ignored
    begin
      exp_t e;
      @(negedge clk);
      apply(2000, 3000, 30000, 100, 200, 300, 400, 500, 600);
      e.res = model(2000, 3000, 30000, 100, 200, 300, 400, 500, 600);
      e.r12 = to12(e.res); e.cyc = cyc + 8; e.tag = "R8 first run";
      q.push_back(e);
      @(negedge clk); start = 1'b0;
      repeat (2) @(negedge clk);
      apply(-9999, 9999, -9999, 9999, -9999, 9999, -9999, 9999, -9999);
      @(negedge clk); start = 1'b0;
      repeat (14) @(negedge clk);
      chk(q.size() == 0, "R8 run completed once", q.size(), 0);
    end

    // back-to-back and pseudo-random vectors
    for (int i = 0; i < 40; i++) begin
      run_vec($urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768,
              $urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768,
              $urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768,
              $urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768,
              $urandom_range(0, 65535) - 32768, "R5 random", 0, 1'b0);
    end

    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R7 all results seen", q.size(), 0);
    finish_run();
  end
endmodule